// File: doc/BRIEF.md
# Color Type to RGBA Pixel Expander

This block turns a stream of 8-bit sample bytes for one image into a stream of RGBA pixels. A start pulse fixes the color type of the image, a 3-bit code, and clears any half-gathered pixel. Bytes then arrive over a valid/ready handshake. The block collects as many bytes as the color type needs for one pixel and emits a single pixel on four 8-bit channel outputs. Missing channels are filled in: a gray level is copied into red, green and blue, and alpha becomes 0xFF when the type has none.

Indexed images use a 256-entry palette held inside the block. The palette is loaded in advance through a write port that takes one index and three color bytes per write. Each index byte then selects a palette color. The output holds a pixel until the consumer accepts it. While a pixel waits, the input stops taking bytes.

Top module: `rgba_expander`

## Requirements
- R1: After reset, `pix_valid` is 0 and `byte_ready` is 1.
- R2: Color code 0 (gray) uses one byte per pixel. The output is R=G=B=byte and A=0xFF.
- R3: Color code 1 (gray with alpha) uses two bytes per pixel. The first byte is copied to R, G and B. The second byte becomes A.
- R4: Color code 2 (RGB) uses three bytes per pixel. They are taken as R, then G, then B, and A=0xFF.
- R5: Color code 3 (RGBA) uses four bytes per pixel, taken as R, G, B, A in that order.
- R6: Color code 4 (indexed) uses one byte per pixel. The byte selects the palette entry, whose stored R, G, B appear on the outputs, and A=0xFF.
- R7: `pix_valid` is high in the cycle after the clock edge that accepts the last byte of a pixel. Each valid cycle carries exactly one pixel.
- R8: While `pix_valid` is 1 and `pix_ready` is 0, the four channels and `pix_valid` stay unchanged and `byte_ready` is 0. When the output is empty or being accepted, `byte_ready` is 1, so one pixel per cycle can flow through.
- R9: A cycle with `img_start` high latches `img_ctype` and discards any partly gathered pixel. `byte_ready` is 0 during that cycle, so no byte is taken.
- R10: A palette entry that has not been written since reset reads as R=G=B=0.
- R11: Color codes 5, 6 and 7 behave exactly like code 0.
- R12: A palette write at a clock edge takes effect for index bytes accepted at later edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| img_start | input | 1 | Start of a new image |
| img_ctype | input | 3 | Color type code, sampled with `img_start` |
| byte_valid | input | 1 | Sample byte offered |
| byte_ready | output | 1 | Block can take a sample byte |
| byte_data | input | 8 | Sample byte |
| pal_wr | input | 1 | Palette write strobe |
| pal_wr_idx | input | 8 | Palette entry to write |
| pal_wr_r | input | 8 | Red value for the entry |
| pal_wr_g | input | 8 | Green value for the entry |
| pal_wr_b | input | 8 | Blue value for the entry |
| pix_valid | output | 1 | A pixel is on the channel outputs |
| pix_ready | input | 1 | Consumer takes the pixel |
| pix_r | output | 8 | Red channel |
| pix_g | output | 8 | Green channel |
| pix_b | output | 8 | Blue channel |
| pix_a | output | 8 | Alpha channel |

## Verification
The bench targets these cases:
- A new start arriving after part of an RGBA pixel has been gathered. A design that kept the stale bytes would shift every later pixel of the next image.
- Random output backpressure while bytes keep coming. A design that overwrote a held pixel or dropped `byte_ready` too late would lose or duplicate pixels.
- Indexed pixels held across stalls, and palette indices that were never written. A wrong design would show a changed color, or leftover memory contents instead of zero.
- Unsupported type codes. A wrong design would consume the wrong number of bytes per pixel.

// File: rtl/rgbx_pkg.sv
package rgbx_pkg;

    parameter int unsigned CH_W = 8;
    localparam int unsigned PAL_AW = CH_W;
    localparam int unsigned PAL_DEPTH = 1 << PAL_AW;
    localparam int unsigned SLOT_W = 2;

    typedef logic [CH_W-1:0] chan_t;

    typedef enum logic [2:0] {
        CT_GRAY   = 3'd0,
        CT_GRAY_A = 3'd1,
        CT_RGB    = 3'd2,
        CT_RGB_A  = 3'd3,
        CT_INDEX  = 3'd4
    } ctype_e;

    typedef struct packed {
        logic  from_pal;
        chan_t r;
        chan_t g;
        chan_t b;
        chan_t a;
    } pix_t;

    // Slot number of the final byte of a pixel for a color code.
    function automatic logic [SLOT_W-1:0] final_slot(input logic [2:0] code);
        case (code)
            CT_GRAY_A: final_slot = 2'd1;
            CT_RGB:    final_slot = 2'd2;
            CT_RGB_A:  final_slot = 2'd3;
            default:   final_slot = 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/rgbx_gather.sv
module rgbx_gather
    import rgbx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic [2:0] ctype_i,
    input  logic       take_i,
    input  chan_t      byte_i,
    output logic       emit_o,
    output pix_t       pix_o
);

    typedef struct packed {
        logic [SLOT_W-1:0] slot;
        logic [2:0]        ctype;
        chan_t             s0;
        chan_t             s1;
        chan_t             s2;
    } gather_t;

    localparam chan_t FULL = '1;

    gather_t st_q, st_d;
    logic [SLOT_W-1:0] last_slot;

    always_comb begin
        st_d      = st_q;
        emit_o    = 1'b0;
        pix_o     = '0;
        last_slot = final_slot(st_q.ctype);

        // Pixel built from stored bytes plus the byte now on the input.
        case (st_q.ctype)
            CT_GRAY_A: pix_o = '{from_pal: 1'b0, r: st_q.s0, g: st_q.s0, b: st_q.s0, a: byte_i};
            CT_RGB:    pix_o = '{from_pal: 1'b0, r: st_q.s0, g: st_q.s1, b: byte_i, a: FULL};
            CT_RGB_A:  pix_o = '{from_pal: 1'b0, r: st_q.s0, g: st_q.s1, b: st_q.s2, a: byte_i};
            CT_INDEX:  pix_o = '{from_pal: 1'b1, r: '0, g: '0, b: '0, a: FULL};
            default:   pix_o = '{from_pal: 1'b0, r: byte_i, g: byte_i, b: byte_i, a: FULL};
        endcase

        if (start_i) begin
            st_d.slot  = '0;
            st_d.ctype = ctype_i;
        end else if (take_i) begin
            case (st_q.slot)
                2'd0:    st_d.s0 = byte_i;
                2'd1:    st_d.s1 = byte_i;
                2'd2:    st_d.s2 = byte_i;
                default: st_d.s2 = st_q.s2;
            endcase
            if (st_q.slot == last_slot) begin
                emit_o    = 1'b1;
                st_d.slot = '0;
            end else begin
                st_d.slot = st_q.slot + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assert_slot_within_pixel_R7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.slot <= final_slot(st_q.ctype));

    assert_start_clears_slot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (st_q.slot == '0));

endmodule

// File: rtl/rgbx_palette.sv
module rgbx_palette
    import rgbx_pkg::*;
#(
    parameter int unsigned DEPTH = PAL_DEPTH,
    localparam int unsigned AW = $clog2(DEPTH),
    localparam int unsigned EW = 3 * CH_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_i,
    input  logic [AW-1:0] wr_idx_i,
    input  chan_t         wr_r_i,
    input  chan_t         wr_g_i,
    input  chan_t         wr_b_i,
    input  logic          rd_i,
    input  logic [AW-1:0] rd_idx_i,
    output chan_t         rd_r_o,
    output chan_t         rd_g_o,
    output chan_t         rd_b_o
);

    typedef struct packed {
        logic [DEPTH-1:0] seen;
        logic [EW-1:0]    rd;
    } pal_t;

    logic [EW-1:0] mem [DEPTH];
    pal_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (rd_i) begin
            st_d.rd = st_q.seen[rd_idx_i] ? mem[rd_idx_i] : '0;
        end
        if (wr_i) begin
            st_d.seen[wr_idx_i] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_i) begin
            mem[wr_idx_i] <= {wr_r_i, wr_g_i, wr_b_i};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign {rd_r_o, rd_g_o, rd_b_o} = st_q.rd;

    assert_unwritten_reads_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && !st_q.seen[rd_idx_i]) |=> (st_q.rd == '0));

    assert_write_marks_entry_R12: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> st_q.seen[$past(wr_idx_i)]);

endmodule

// File: rtl/rgbx_hold.sv
module rgbx_hold
    import rgbx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  pix_t pix_i,
    input  logic ready_i,
    output logic valid_o,
    output pix_t pix_o
);

    typedef struct packed {
        logic valid;
        pix_t pix;
    } hold_t;

    hold_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.valid = 1'b1;
            st_d.pix   = pix_i;
        end else if (ready_i) begin
            st_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid_o = st_q.valid;
    assign pix_o   = st_q.pix;

    assert_stall_keeps_pixel_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.valid && !ready_i) |=> (st_q.valid && $stable(st_q.pix)));

    assert_no_overwrite_R8: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> (!st_q.valid || ready_i));

endmodule

// File: rtl/rgba_expander.sv
module rgba_expander
    import rgbx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       img_start,
    input  logic [2:0] img_ctype,
    input  logic       byte_valid,
    output logic       byte_ready,
    input  logic [7:0] byte_data,
    input  logic       pal_wr,
    input  logic [7:0] pal_wr_idx,
    input  logic [7:0] pal_wr_r,
    input  logic [7:0] pal_wr_g,
    input  logic [7:0] pal_wr_b,
    output logic       pix_valid,
    input  logic       pix_ready,
    output logic [7:0] pix_r,
    output logic [7:0] pix_g,
    output logic [7:0] pix_b,
    output logic [7:0] pix_a
);

    logic  take;
    logic  emit;
    pix_t  built;
    pix_t  held;
    logic  held_valid;
    chan_t pal_r, pal_g, pal_b;

    assign byte_ready = !img_start && (!held_valid || pix_ready);
    assign take       = byte_valid && byte_ready;

    rgbx_gather u_gather (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (img_start),
        .ctype_i (img_ctype),
        .take_i  (take),
        .byte_i  (byte_data),
        .emit_o  (emit),
        .pix_o   (built)
    );

    rgbx_palette #(.DEPTH(PAL_DEPTH)) u_palette (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (pal_wr),
        .wr_idx_i (pal_wr_idx),
        .wr_r_i   (pal_wr_r),
        .wr_g_i   (pal_wr_g),
        .wr_b_i   (pal_wr_b),
        .rd_i     (emit && built.from_pal),
        .rd_idx_i (byte_data),
        .rd_r_o   (pal_r),
        .rd_g_o   (pal_g),
        .rd_b_o   (pal_b)
    );

    rgbx_hold u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (emit),
        .pix_i   (built),
        .ready_i (pix_ready),
        .valid_o (held_valid),
        .pix_o   (held)
    );

    assign pix_valid = held_valid;
    assign pix_r     = held.from_pal ? pal_r : held.r;
    assign pix_g     = held.from_pal ? pal_g : held.g;
    assign pix_b     = held.from_pal ? pal_b : held.b;
    assign pix_a     = held.a;

endmodule

// File: tb/tb_rgba_expander.sv
module tb_rgba_expander;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       img_start = 1'b0;
    logic [2:0] img_ctype = 3'd0;
    logic       byte_valid = 1'b0;
    logic       byte_ready;
    logic [7:0] byte_data = 8'h00;
    logic       pal_wr = 1'b0;
    logic [7:0] pal_wr_idx = 8'h00;
    logic [7:0] pal_wr_r = 8'h00, pal_wr_g = 8'h00, pal_wr_b = 8'h00;
    logic       pix_valid;
    logic       pix_ready = 1'b1;
    logic [7:0] pix_r, pix_g, pix_b, pix_a;

    rgba_expander dut (.*);

    int    vectors = 0;
    int    miscmp  = 0;
    int    cyc     = 0;
    string cur_req = "R1";

    // Behavioural reference state
    bit          m_valid = 0;
    logic [31:0] m_pix   = '0;
    int          m_type  = 0;
    int          byteq[$];
    logic [23:0] pal_mem [256];
    bit          pal_ok  [256];
    bit          bp_on = 0;
    logic [7:0]  lfsr = 8'hA5;

    function automatic int bytes_per_pix(input int t);
        case (t)
            1: return 2;
            2: return 3;
            3: return 4;
            default: return 1;
        endcase
    endfunction

    function automatic logic [31:0] make_pix();
        case (m_type)
            1: return {byteq[0][7:0], byteq[0][7:0], byteq[0][7:0], byteq[1][7:0]};
            2: return {byteq[0][7:0], byteq[1][7:0], byteq[2][7:0], 8'hFF};
            3: return {byteq[0][7:0], byteq[1][7:0], byteq[2][7:0], byteq[3][7:0]};
            4: return pal_ok[byteq[0]] ? {pal_mem[byteq[0]], 8'hFF} : 32'h000000FF;
            default: return {byteq[0][7:0], byteq[0][7:0], byteq[0][7:0], 8'hFF};
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_valid = 0;
            m_type  = 0;
            byteq.delete();
            for (int i = 0; i < 256; i++) pal_ok[i] = 0;
        end else begin
            bit acc;
            acc = byte_valid && !img_start && (!m_valid || pix_ready);
            if (m_valid && pix_ready) m_valid = 0;
            if (img_start) begin
                byteq.delete();
                m_type = int'(img_ctype);
            end else if (acc) begin
                byteq.push_back(int'(byte_data));
                if (byteq.size() == bytes_per_pix(m_type)) begin
                    m_pix   = make_pix();
                    m_valid = 1;
                    byteq.delete();
                end
            end
            if (pal_wr) begin
                pal_mem[pal_wr_idx] = {pal_wr_r, pal_wr_g, pal_wr_b};
                pal_ok[pal_wr_idx]  = 1;
            end
        end
    end

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscmp++;
            $display("FAIL %s %s actual=%h expected=%h at cycle %0d", cur_req, what, act, exp, cyc);
        end
    endtask

    // Compare with the model every cycle, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk("pix_valid", {31'd0, pix_valid}, {31'd0, m_valid});
            chk("byte_ready", {31'd0, byte_ready},
                {31'd0, (!img_start && (!m_valid || pix_ready))});
            if (m_valid) chk("pixel", {pix_r, pix_g, pix_b, pix_a}, m_pix);
        end
    end

    // Output backpressure pattern
    always @(negedge clk) begin
        #1;
        if (bp_on) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            pix_ready = lfsr[0];
        end else begin
            pix_ready = 1'b1;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            miscmp++;
            $display("FAIL watchdog expired actual=%0d expected<=%0d", cyc, 50000);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
            $finish;
        end
    end

    task automatic push(input logic [7:0] b);
        bit done = 0;
        while (!done) begin
            @(negedge clk); #2;
            byte_valid = 1'b1;
            byte_data  = b;
            #1;
            done = byte_ready;
            @(posedge clk);
        end
    endtask

    task automatic idle(input int n);
        @(negedge clk); #2;
        byte_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic begin_img(input logic [2:0] c);
        @(negedge clk); #2;
        byte_valid = 1'b0;
        img_start  = 1'b1;
        img_ctype  = c;
        @(negedge clk); #2;
        img_start  = 1'b0;
    endtask

    task automatic pal_load(input logic [7:0] i, input logic [23:0] c);
        @(negedge clk); #2;
        pal_wr = 1'b1;
        pal_wr_idx = i;
        {pal_wr_r, pal_wr_g, pal_wr_b} = c;
        @(negedge clk); #2;
        pal_wr = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk); #3;
        cur_req = "R1";
        chk("reset pix_valid", {31'd0, pix_valid}, 32'd0);
        chk("reset byte_ready", {31'd0, byte_ready}, 32'd1);

        cur_req = "R12";
        pal_load(8'd3, 24'h112233);
        pal_load(8'd7, 24'hED1C24);
        pal_load(8'd200, 24'h3F48CC);
        pal_load(8'd255, 24'hFFAEC9);

        cur_req = "R6";
        begin_img(3'd4);
        push(8'd3); push(8'd7); push(8'd200); push(8'd255); push(8'd3);
        idle(3);

        cur_req = "R10";
        begin_img(3'd4);
        push(8'd9); push(8'd0); push(8'd7);
        idle(3);

        cur_req = "R2";
        begin_img(3'd0);
        push(8'h00); push(8'h7F); push(8'hFF); push(8'h12);
        idle(3);

        cur_req = "R3";
        begin_img(3'd1);
        push(8'h11); push(8'h22); push(8'h33); push(8'h44);
        idle(3);

        cur_req = "R4";
        begin_img(3'd2);
        push(8'hFF); push(8'hF2); push(8'h00); push(8'h7F); push(8'h7F); push(8'h7F);
        idle(3);

        cur_req = "R5";
        begin_img(3'd3);
        push(8'hED); push(8'h1C); push(8'h24); push(8'h80);
        push(8'h01); push(8'h02); push(8'h03); push(8'h04);
        idle(3);

        cur_req = "R11";
        begin_img(3'd6);
        push(8'h5A); push(8'hA5);
        begin_img(3'd7);
        push(8'h3C);
        idle(3);

        cur_req = "R9";
        begin_img(3'd3);
        push(8'hAA); push(8'hBB);
        begin_img(3'd2);
        push(8'h10); push(8'h20); push(8'h30);
        begin_img(3'd1);
        push(8'h99);
        begin_img(3'd0);
        push(8'h42);
        idle(3);

        cur_req = "R7";
        begin_img(3'd2);
        for (int k = 0; k < 12; k++) push(8'(k * 17));
        idle(3);

        cur_req = "R8";
        bp_on = 1;
        begin_img(3'd3);
        for (int k = 0; k < 16; k++) push(8'(k * 29 + 3));
        begin_img(3'd4);
        push(8'd7); push(8'd200); push(8'd9); push(8'd255); push(8'd3);
        begin_img(3'd1);
        for (int k = 0; k < 10; k++) push(8'(255 - k * 13));
        begin_img(3'd0);
        for (int k = 0; k < 10; k++) push(8'(k + 100));
        idle(20);
        bp_on = 0;
        idle(10);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
        $finish;
    end

endmodule